// File: doc/BRIEF.md
# Byte-Laned Static RAM Emulator

This block is a clocked stand-in for a 16-bit-wide asynchronous static RAM. It gives FPGA prototypes and simulation models the control behaviour of such a memory without analog timing. Five active-low controls are sampled on every rising clock edge:

- chip select
- output enable
- write enable
- lower byte select
- upper byte select

The block decodes them into one of these modes:

- standby
- output disable
- read of either or both byte lanes
- write of either or both byte lanes

It also keeps a separate drive state for each 8-bit lane.

The bidirectional data bus is split into three parts: a write-data input, a registered read-data output, and a two-bit lane drive-enable output. Bit 0 of the drive enable covers data bits 7:0 and bit 1 covers bits 15:8. There are no internal tri-states. A wrapper at the pad level can merge the three into an inout bus.

The address is 18 bits wide, for 2^18 words. The number of words actually stored can be reduced with a parameter. When it is reduced, the upper address bits do not take part in the lookup.

Top module: `sram_lane_emu`

## Requirements
- R1: While reset is low, and on the first edge after it, both lane drive enables are 0 and the read data is 0.
- R2: A cycle sampled with chip select high produces lane drive enables 2'b00 and writes nothing, whatever the other controls are.
- R3: A cycle sampled with chip select low, write enable high and output enable high produces lane drive enables 2'b00 and writes nothing.
- R4: A cycle sampled with chip select low, output enable low and write enable high sets lane drive enable bit 0 to the inverse of the lower byte select and bit 1 to the inverse of the upper byte select. The outputs change on the edge that samples the controls.
- R5: After such a read cycle, each driven lane carries the stored byte of the addressed word: bits 7:0 for the lower lane and bits 15:8 for the upper lane.
- R6: A cycle sampled with chip select and write enable low stores write-data bits 7:0 when the lower select is low and bits 15:8 when the upper select is low. In that cycle output enable has no effect and both lane drive enables are 0.
- R7: During a write, a lane whose byte select is high keeps its previous content.
- R8: A cycle with chip select low and both byte selects high neither drives nor writes.
- R9: Only the low MEM_AW address bits choose the stored word. Addresses that differ only above them refer to the same word.
- R10: A word written on one edge is returned by a read sampled on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the output state |
| addr_i | input | ADDR_W | Word address |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| lb_n_i | input | 1 | Lower byte (bits 7:0) select, active low |
| ub_n_i | input | 1 | Upper byte (bits 15:8) select, active low |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| lane_oe_o | output | 2 | Per-lane drive enable, bit 0 lower lane, bit 1 upper lane |

## Verification
Controls and data presented before edge N affect both the lane drive enables and the read data right after edge N, with a single register in the path. A write committed at edge N is therefore visible to a read sampled at edge N+1. The bench drives on the falling edge. It computes the expected enables and byte values from the controls and a shadow copy of the memory taken before edge N, and compares them on the following falling edge. Every byte-select and mode combination is swept on several addresses, and each combination is followed by a full-word read that exposes any lane that was changed and should not have been.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
    localparam int NUM_LANES = 2;
    localparam int LANE_BITS = 8;
    localparam int WORD_BITS = NUM_LANES * LANE_BITS;

    // decoded intent of one sampled control set
    typedef struct packed {
        logic [NUM_LANES-1:0] lane_rd;
        logic [NUM_LANES-1:0] lane_wr;
    } dec_t;

    // registered output state
    typedef struct packed {
        logic [WORD_BITS-1:0] rdata;
        logic [NUM_LANES-1:0] lane_oe;
    } out_state_t;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
    import sram_emu_pkg::*;
(
    input  logic cs_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic lb_n,
    input  logic ub_n,
    output dec_t dec
);
    logic [NUM_LANES-1:0] sel;

    assign sel = {~ub_n, ~lb_n};

    always_comb begin
        dec = '0;
        if (!cs_n && (sel != '0)) begin
            if (!we_n) begin
                // write wins; output enable plays no part
                dec.lane_wr = sel;
            end else if (!oe_n) begin
                dec.lane_rd = sel;
            end
        end
    end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int AW = 8,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/sram_lane_emu.sv
module sram_lane_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int MEM_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 cs_n_i,
    input  logic                 oe_n_i,
    input  logic                 we_n_i,
    input  logic                 lb_n_i,
    input  logic                 ub_n_i,
    input  logic [WORD_BITS-1:0] wdata_i,
    output logic [WORD_BITS-1:0] rdata_o,
    output logic [NUM_LANES-1:0] lane_oe_o
);
    logic [MEM_AW-1:0]    word_addr;
    dec_t                 dec;
    logic [WORD_BITS-1:0] bank_rdata;
    out_state_t           st_d, st_q;

    assign word_addr = addr_i[MEM_AW-1:0];

    generate
        if (ADDR_W > MEM_AW) begin : g_alias
            logic unused_hi_addr;
            assign unused_hi_addr = ^addr_i[ADDR_W-1:MEM_AW];
        end
    endgenerate

    sram_mode_dec dec_i (
        .cs_n (cs_n_i),
        .oe_n (oe_n_i),
        .we_n (we_n_i),
        .lb_n (lb_n_i),
        .ub_n (ub_n_i),
        .dec  (dec)
    );

    generate
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            sram_lane_bank #(
                .AW (MEM_AW),
                .W  (LANE_BITS)
            ) bank_i (
                .clk   (clk),
                .wr_en (dec.lane_wr[l]),
                .addr  (word_addr),
                .wdata (wdata_i[l*LANE_BITS +: LANE_BITS]),
                .rdata (bank_rdata[l*LANE_BITS +: LANE_BITS])
            );
        end
    endgenerate

    always_comb begin
        st_d         = st_q;
        st_d.lane_oe = dec.lane_rd;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (dec.lane_rd[l]) begin
                st_d.rdata[l*LANE_BITS +: LANE_BITS] = bank_rdata[l*LANE_BITS +: LANE_BITS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o   = st_q.rdata;
    assign lane_oe_o = st_q.lane_oe;
endmodule

// File: rtl/sram_lane_emu_chk.sv
module sram_lane_emu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_i,
    input logic       oe_n_i,
    input logic       we_n_i,
    input logic       lb_n_i,
    input logic       ub_n_i,
    input logic [1:0] lane_oe_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> lane_oe_o == 2'b00);

    assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cs_n_i) |-> lane_oe_o == 2'b00);

    assert_out_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!cs_n_i && we_n_i && oe_n_i) |-> lane_oe_o == 2'b00);

    assert_read_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!cs_n_i && we_n_i && !oe_n_i)
        |-> lane_oe_o == $past({~ub_n_i, ~lb_n_i}));

    assert_write_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!cs_n_i && !we_n_i) |-> lane_oe_o == 2'b00);

    assert_no_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(lb_n_i && ub_n_i) |-> lane_oe_o == 2'b00);
endmodule

bind sram_lane_emu sram_lane_emu_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .oe_n_i    (oe_n_i),
    .we_n_i    (we_n_i),
    .lb_n_i    (lb_n_i),
    .ub_n_i    (ub_n_i),
    .lane_oe_o (lane_oe_o)
);

// File: tb/sram_lane_emu_tb_top.sv
`timescale 1ns/1ps
module sram_lane_emu_tb_top;
    localparam int ADDR_W = 18;
    localparam int MEM_AW = 8;
    localparam int DEPTH  = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic [1:0]        lane_oe;

    logic [15:0] shadow [DEPTH];
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sram_lane_emu #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .cs_n_i    (cs_n),
        .oe_n_i    (oe_n),
        .we_n_i    (we_n),
        .lb_n_i    (lb_n),
        .ub_n_i    (ub_n),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .lane_oe_o (lane_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, outputs due after the next posedge
    task automatic apply(input logic [ADDR_W-1:0] a, input logic cs, input logic oe,
                         input logic we, input logic lb, input logic ub,
                         input logic [15:0] d, input string dtag);
        logic [1:0]  eo;
        logic [15:0] old;
        string       tag;
        int          idx;
        idx = int'(a[MEM_AW-1:0]);
        old = shadow[idx];
        addr = a; cs_n = cs; oe_n = oe; we_n = we; lb_n = lb; ub_n = ub; wdata = d;
        if (cs) begin
            eo = 2'b00; tag = "R2";
        end else if (lb && ub) begin
            eo = 2'b00; tag = "R8";
        end else if (!we) begin
            eo = 2'b00; tag = "R6";
            if (!lb) shadow[idx][7:0]  = d[7:0];
            if (!ub) shadow[idx][15:8] = d[15:8];
        end else if (oe) begin
            eo = 2'b00; tag = "R3";
        end else begin
            eo = {~ub, ~lb}; tag = "R4";
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " lane enables"}, {14'd0, lane_oe}, {14'd0, eo});
        if (eo[0]) check({dtag, " low byte"},  {8'd0, rdata[7:0]},  {8'd0, old[7:0]});
        if (eo[1]) check({dtag, " high byte"}, {8'd0, rdata[15:8]}, {8'd0, old[15:8]});
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset enables", {14'd0, lane_oe}, 16'd0);
        check("R1 reset data", rdata, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first edge enables", {14'd0, lane_oe}, 16'd0);

        // preload every word with a full write (R6), then read it all back (R5)
        for (int i = 0; i < DEPTH; i++)
            apply(ADDR_W'(i), 0, 0, 0, 0, 0, 16'(i * 16'h0301 + 16'h5a00), "R5");
        for (int i = 0; i < DEPTH; i++)
            apply(ADDR_W'(i), 0, 0, 1, 0, 0, 16'hffff, "R5");

        // every control combination on several addresses, each followed by a full read (R7)
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 32; c++) begin
                logic [ADDR_W-1:0] a;
                a = ADDR_W'(k * 37 + 3);
                apply(a, c[4], c[3], c[2], c[1], c[0], 16'($urandom), "R5");
                apply(a, 0, 0, 1, 0, 0, 16'h0000, "R7");
            end
        end

        // write then read on the very next edge (R10)
        apply(18'd9, 0, 1, 0, 0, 0, 16'hbeef, "R10");
        apply(18'd9, 0, 0, 1, 0, 0, 16'h0000, "R10");
        apply(18'd9, 0, 0, 0, 1, 0, 16'h1200, "R10");
        apply(18'd9, 0, 0, 1, 0, 0, 16'h0000, "R10");

        // upper address bits alias onto the same word (R9)
        apply({10'h3ff, 8'd77}, 0, 0, 0, 0, 0, 16'hc3a5, "R9");
        apply({10'h000, 8'd77}, 0, 0, 1, 0, 0, 16'h0000, "R9");
        apply({10'h155, 8'd77}, 0, 0, 1, 1, 0, 16'h0000, "R9");

        // random mix of byte-lane traffic
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] c;
            c = 5'($urandom);
            if ($urandom_range(0, 7) != 0) c[4] = 1'b0;
            apply(ADDR_W'($urandom), c[4], c[3], c[2], c[1], c[0], 16'($urandom), "R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule